// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, for every fetch slot of a multithreaded front end, which hardware thread is allowed to fetch. Each thread presents a three-bit fetch state, an active bit, and two occupancy counts: one for its instruction queue and one for its load/store queue. A policy input picks how the winner is chosen. The block answers in the same cycle with a thread index and a valid flag. A clear valid flag means no thread can fetch.

Four policies are supported. The fixed policy always names thread 0. The rotating policy keeps an ordered list of thread indices. It grants the first thread in the list that can fetch, and once that grant is taken the winner moves to the tail of the list. The two occupancy policies grant the fetchable thread with the largest instruction-queue count or the largest load/store-queue count. Any other policy value yields no grant.

When the block is built for a single thread, it ignores the policy input. In that build it grants thread 0 whenever that thread can fetch.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread can fetch only when its active bit is set and its state is 0 (running), 1 (idle) or 4 (cache line returned). State values 2, 3, 5, 6 and 7 keep the thread out of every policy except the fixed one.
- R2: Under policy 1 (rotating), the grant is the first thread in the priority list that can fetch.
- R3: When a rotating grant is taken (`grant_take` high with a valid grant under policy 1), the granted thread is removed from its place in the list at the next clock edge. It is placed at the tail, and the threads that were behind it each move forward one place.
- R4: If no thread in the list can fetch, `grant_vld` is 0 and the list order is unchanged, even when `grant_take` is high.
- R5: After reset the list holds the thread indices in ascending order, so with all threads able to fetch the first rotating grant goes to thread 0.
- R6: Under policy 0 (fixed), and with more than one thread built, the grant is always valid and names thread 0.
- R7: Under policy 2, the grant goes to the fetchable thread with the largest instruction-queue count. Equal counts resolve to the lower thread index.
- R8: Under policy 3, the grant goes to the fetchable thread with the largest load/store-queue count. Equal counts resolve to the lower thread index.
- R9: Policy values 4 to 7 give `grant_vld` = 0.
- R10: The grant follows the present inputs within the same cycle. A taken grant under any policy other than 1 leaves the list order unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 3 | Policy: 0 fixed, 1 rotating, 2 instruction-queue count, 3 load/store-queue count |
| thr_state | input | NTHR*3 | Per-thread fetch state, thread t in bits [3t+2:3t] |
| act_mask | input | NTHR | Per-thread active bit |
| iq_cnt | input | NTHR*CNT_W | Per-thread instruction-queue occupancy, thread t in field t |
| lsq_cnt | input | NTHR*CNT_W | Per-thread load/store-queue occupancy, thread t in field t |
| grant_take | input | 1 | The consumer accepts this cycle's grant |
| grant_vld | output | 1 | A thread is granted |
| grant_id | output | TID_W | Granted thread index |

## Verification
Two things can happen in one cycle under the rotating policy: a grant is made and the list rotates, and the next lookup must already see the new order. The bench keeps `grant_take` high across long runs of rotating grants while the fetch states change. Its own queue model predicts the winner of each cycle from the rotated order. A second case is a take that arrives while no thread can fetch, or while a count policy is selected. This is judged by switching back to the rotating policy and confirming that the next winner follows the unchanged order.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_STALL   = 3'd3,
    ST_LINE_OK = 3'd4,
    ST_WAIT_RD = 3'd5,
    ST_WAIT_RT = 3'd6,
    ST_PARKED  = 3'd7
  } fetch_state_e;

  typedef enum logic [2:0] {
    POL_FIXED = 3'd0,
    POL_ROT   = 3'd1,
    POL_IQ    = 3'd2,
    POL_LSQ   = 3'd3
  } fetch_pol_e;

  // States in which a thread may be handed a fetch slot.
  function automatic logic may_fetch(input logic [2:0] st);
    return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_LINE_OK);
  endfunction

  function automatic logic pol_legal(input logic [2:0] p);
    return p <= 3'd3;
  endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig #(
  parameter int NTHR = 4
) (
  input  logic [NTHR*3-1:0] st_vec,
  input  logic [NTHR-1:0]   act,
  output logic [NTHR-1:0]   elig
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign elig[t] = act[t] && fsel_pkg::may_fetch(st_vec[t*3 +: 3]);
  end
endmodule

// File: rtl/fsel_rot_order.sv
module fsel_rot_order #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  elig,
  input  logic             adv,
  output logic             rr_vld,
  output logic [TID_W-1:0] rr_id
);
  logic [TID_W-1:0] ord_q [NTHR];
  logic [NTHR*TID_W-1:0] ord_flat;
  logic [TID_W-1:0] pos;

  always_comb begin
    rr_vld = 1'b0;
    rr_id  = '0;
    pos    = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (!rr_vld && elig[ord_q[i]]) begin
        rr_vld = 1'b1;
        rr_id  = ord_q[i];
        pos    = TID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) ord_q[i] <= TID_W'(i);
    end else if (adv && rr_vld) begin
      for (int i = 0; i < NTHR - 1; i++) begin
        if (TID_W'(i) >= pos) ord_q[i] <= ord_q[i+1];
      end
      ord_q[NTHR-1] <= rr_id;
    end
  end

  for (genvar i = 0; i < NTHR; i++) begin : g_flat
    assign ord_flat[i*TID_W +: TID_W] = ord_q[i];
  end

  function automatic int seen_count(input logic [NTHR*TID_W-1:0] f);
    logic [NTHR-1:0] seen;
    seen = '0;
    for (int i = 0; i < NTHR; i++) seen[f[i*TID_W +: TID_W]] = 1'b1;
    return $countones(seen);
  endfunction

  // R3: the taken thread lands at the tail
  p_rotate_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rr_vld) |=> ord_q[NTHR-1] == $past(rr_id));

  // R4 / R10: without a taken grant the order holds
  p_order_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && rr_vld) |=> $stable(ord_flat));

  // R5: the list always holds every thread exactly once
  p_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_count(ord_flat) == NTHR);
endmodule

// File: rtl/fsel_cnt_pick.sv
module fsel_cnt_pick #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6,
  parameter int TID_W = 2
) (
  input  logic [NTHR*CNT_W-1:0] cnt,
  input  logic [NTHR-1:0]       elig,
  output logic                  pk_vld,
  output logic [TID_W-1:0]      pk_id
);
  logic [CNT_W-1:0] best;

  // Ascending scan with a strict compare keeps the lowest index on ties.
  always_comb begin
    pk_vld = 1'b0;
    pk_id  = '0;
    best   = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (elig[t] && (!pk_vld || cnt[t*CNT_W +: CNT_W] > best)) begin
        pk_vld = 1'b1;
        pk_id  = TID_W'(t);
        best   = cnt[t*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            pol_sel,
  input  logic [NTHR*3-1:0]     thr_state,
  input  logic [NTHR-1:0]       act_mask,
  input  logic [NTHR*CNT_W-1:0] iq_cnt,
  input  logic [NTHR*CNT_W-1:0] lsq_cnt,
  input  logic                  grant_take,
  output logic                  grant_vld,
  output logic [TID_W-1:0]      grant_id
);
  import fsel_pkg::*;

  logic [NTHR-1:0] elig;

  fsel_elig #(.NTHR(NTHR)) u_elig (
    .st_vec (thr_state),
    .act    (act_mask),
    .elig   (elig)
  );

  if (NTHR == 1) begin : g_one
    // Single thread built: policy does not matter.
    assign grant_vld = elig[0];
    assign grant_id  = '0;
  end else begin : g_multi
    logic rr_vld, iq_vld, lq_vld, rot_adv;
    logic [TID_W-1:0] rr_id, iq_id, lq_id;

    assign rot_adv = grant_take && (pol_sel == POL_ROT);

    fsel_rot_order #(.NTHR(NTHR), .TID_W(TID_W)) u_rot (
      .clk    (clk),
      .rst_n  (rst_n),
      .elig   (elig),
      .adv    (rot_adv),
      .rr_vld (rr_vld),
      .rr_id  (rr_id)
    );

    fsel_cnt_pick #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_iq (
      .cnt    (iq_cnt),
      .elig   (elig),
      .pk_vld (iq_vld),
      .pk_id  (iq_id)
    );

    fsel_cnt_pick #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_lsq (
      .cnt    (lsq_cnt),
      .elig   (elig),
      .pk_vld (lq_vld),
      .pk_id  (lq_id)
    );

    always_comb begin
      grant_vld = 1'b0;
      grant_id  = '0;
      case (pol_sel)
        POL_FIXED: begin grant_vld = 1'b1;   grant_id = '0;    end
        POL_ROT:   begin grant_vld = rr_vld; grant_id = rr_id; end
        POL_IQ:    begin grant_vld = iq_vld; grant_id = iq_id; end
        POL_LSQ:   begin grant_vld = lq_vld; grant_id = lq_id; end
        default:   begin grant_vld = 1'b0;   grant_id = '0;    end
      endcase
    end
  end

  // R1: a non-fixed grant always names a thread that may fetch
  p_grant_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && pol_sel != 3'd0) |-> elig[grant_id]);

  // R9: illegal policy codes never grant
  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_legal(pol_sel) |-> !grant_vld);

  // R6: fixed policy names thread 0
  p_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 3'd0 && NTHR > 1) |-> (grant_vld && grant_id == '0));
endmodule

// File: tb/test_fetch_thread_sel.sv
module test_fetch_thread_sel;
  localparam int NTHR  = 4;
  localparam int CNT_W = 6;
  localparam int TID_W = 2;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pol_sel = '0;
  logic [NTHR*3-1:0] thr_state = '0;
  logic [NTHR-1:0] act_mask = '0;
  logic [NTHR*CNT_W-1:0] iq_cnt = '0, lsq_cnt = '0;
  logic grant_take = 1'b0;
  logic grant_vld;
  logic [TID_W-1:0] grant_id;

  int n_vec = 0, n_bad = 0;
  int order[$];

  always #(CLK_P/2) clk = ~clk;

  fetch_thread_sel #(.NTHR(NTHR), .CNT_W(CNT_W)) i_fetch_thread_sel (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .thr_state(thr_state),
    .act_mask(act_mask), .iq_cnt(iq_cnt), .lsq_cnt(lsq_cnt),
    .grant_take(grant_take), .grant_vld(grant_vld), .grant_id(grant_id)
  );

  function automatic bit can_go(int t);
    int s;
    s = int'(thr_state[t*3 +: 3]);
    return act_mask[t] && (s == 0 || s == 1 || s == 4);
  endfunction

  // Reference: returns -1 when no grant, else thread index and queue slot.
  task automatic predict(output int id, output int slot);
    int bc;
    id = -1; slot = -1; bc = -1;
    case (int'(pol_sel))
      0: id = 0;
      1: foreach (order[k]) if (id < 0 && can_go(order[k])) begin id = order[k]; slot = k; end
      2: for (int t = 0; t < NTHR; t++)
           if (can_go(t) && int'(iq_cnt[t*CNT_W +: CNT_W]) > bc) begin id = t; bc = int'(iq_cnt[t*CNT_W +: CNT_W]); end
      3: for (int t = 0; t < NTHR; t++)
           if (can_go(t) && int'(lsq_cnt[t*CNT_W +: CNT_W]) > bc) begin id = t; bc = int'(lsq_cnt[t*CNT_W +: CNT_W]); end
      default: id = -1;
    endcase
  endtask

  // Inputs are set at the negedge, compared a quarter period later,
  // and the model rotates for the following posedge.
  task automatic step(input string rq);
    int id, slot;
    #(CLK_P/4);
    predict(id, slot);
    n_vec++;
    if (grant_vld !== (id >= 0) || (id >= 0 && int'(grant_id) != id)) begin
      n_bad++;
      $display("FAIL %s: vld=%0b id=%0d expected vld=%0b id=%0d",
               rq, grant_vld, grant_id, id >= 0, id);
    end
    if (grant_take && pol_sel == 3'd1 && slot >= 0) begin
      order.delete(slot);
      order.push_back(id);
    end
    @(negedge clk);
  endtask

  task automatic all_state(input int s);
    for (int t = 0; t < NTHR; t++) thr_state[t*3 +: 3] = 3'(s);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NTHR; t++) order.push_back(t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: reset order, all fetchable
    pol_sel = 3'd1; act_mask = '1; all_state(0);
    step("R5");
    // R3: taken rotating grants walk the list
    grant_take = 1'b1;
    repeat (6) step("R3");
    // R2: skip non-fetchable threads at the front
    thr_state[0 +: 3] = 3'd3; thr_state[3 +: 3] = 3'd5;
    repeat (4) step("R2");
    // R4: nothing fetchable with take high; order must hold
    all_state(2);
    repeat (3) step("R4");
    all_state(0);
    step("R4");
    // R10: takes under a count policy leave the order alone
    pol_sel = 3'd2;
    repeat (3) step("R10");
    pol_sel = 3'd1;
    step("R10");
    // R1: every state code and the active mask
    grant_take = 1'b0;
    for (int s = 0; s < 8; s++) begin
      all_state(s);
      step("R1");
      act_mask = 4'b0101;
      step("R1");
      act_mask = '1;
    end
    all_state(0);
    // R7: ties go low, largest wins
    pol_sel = 3'd2; iq_cnt = '0;
    step("R7");
    iq_cnt[2*CNT_W +: CNT_W] = 6'd40; iq_cnt[3*CNT_W +: CNT_W] = 6'd40;
    step("R7");
    thr_state[2*3 +: 3] = 3'd6;
    step("R7");
    all_state(0);
    // R8
    pol_sel = 3'd3; lsq_cnt = '0;
    lsq_cnt[1*CNT_W +: CNT_W] = 6'd63; lsq_cnt[3*CNT_W +: CNT_W] = 6'd63;
    step("R8");
    act_mask = 4'b0101;
    step("R8");
    act_mask = '1;
    // R6 and R9
    pol_sel = 3'd0; all_state(3);
    step("R6");
    for (int p = 4; p < 8; p++) begin
      pol_sel = 3'(p); all_state(0);
      step("R9");
    end
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      pol_sel    = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
      act_mask   = NTHR'($urandom);
      thr_state  = (NTHR*3)'($urandom);
      iq_cnt     = (NTHR*CNT_W)'({$urandom, $urandom});
      lsq_cnt    = (NTHR*CNT_W)'({$urandom, $urandom});
      grant_take = $urandom % 4 != 0;
      if (n % 8 == 0) iq_cnt = '0;
      step(pol_sel == 3'd1 ? "R3" : pol_sel == 3'd2 ? "R7" :
           pol_sel == 3'd3 ? "R8" : pol_sel == 3'd0 ? "R6" : "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule